// File: doc/BRIEF.md
# UART Interrupt Source Controller

This block collects the interrupt conditions of one FIFO-based UART channel, keeps a pending latch for each of seven sources, and clears every latch by the event that belongs to that source. The sources are the receive level crossing the trigger, a receive idle timeout, the transmit holding side becoming empty, a modem status change, detection of a flow-stop or special character, and rising edges on the clear-to-send input and the request-to-send output while their automatic flow control is on.

Register accesses arrive as one-cycle strobes from the register file (identification read, transmit write, modem status read, receive data read). The block returns the raw pending vector, a 6-bit identification code for the highest-priority enabled source, and a combined interrupt line. A read of the identification register clears only the source whose code that read returned. The FIFO storage, shifters and baud generator are outside the block. The baud side supplies one tick per bit time.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset `pend_o` is 0, `iir_o` is 6'h01 and `irq_o` is 0.
- R2: Pending bit 0 (receive trigger) is 1 in the cycle after `rx_level_i >= rx_trig_i` and 0 in the cycle after the level is below the trigger. No register access clears it.
- R3: Pending bit 1 (receive timeout) sets on the 52nd (4*CHAR_BITS+12, CHAR_BITS=10) `rx_bit_tick_i` counted while the level is nonzero and no `rx_push_i` or `rbr_rd_i` occurs. A push, a receive read or an empty FIFO restarts the count. Only `rbr_rd_i` clears the bit.
- R4: Pending bit 2 (transmit empty) sets on a 0-to-1 change of `thr_empty_i`. It clears on `thr_wr_i`, or on `iir_rd_i` while `iir_o` is 6'h02.
- R5: Pending bit 3 (modem status) sets when any bit of `msr_delta_i[3:0]` is 1. Only `msr_rd_i` clears it.
- R6: Pending bit 4 (flow stop / special) sets on `xoff_det_i` or `spec_det_i`. It clears on `xon_rx_i`, on `iir_rd_i` while `iir_o` is 6'h10, or on a later `rx_push_i` if the last setting event included `spec_det_i`.
- R7: Pending bits 5 and 6 set on a 0-to-1 change of `cts_i` and `rts_i` while `cts_auto_en_i` and `rts_auto_en_i` are high. `msr_rd_i` clears both. `iir_rd_i` with `iir_o` equal to 6'h20 clears bit 5 if it is enabled and pending, and bit 6 otherwise.
- R8: Among enabled pending sources, priority runs from bit 0 (highest) to bit 6. The codes are: bit 0 6'h04, bit 1 6'h0C, bit 2 6'h02, bit 3 6'h00, bit 4 6'h10, bits 5/6 6'h20. The code is 6'h01 when none is active.
- R9: `irq_en_i[k]` gates source k into `iir_o` and `irq_o` only. `pend_o` keeps its state while the enable is low.
- R10: An identification read clears only the source whose code it returned. Other pending bits stay set.
- R11: When a source's set event and clear event fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_level_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive trigger level |
| rx_push_i | input | 1 | Character written into receive FIFO |
| rx_bit_tick_i | input | 1 | One pulse per bit time |
| rbr_rd_i | input | 1 | Receive data register read strobe |
| thr_empty_i | input | 1 | Transmit holding/FIFO empty level |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| msr_delta_i | input | 4 | Modem status change bits |
| msr_rd_i | input | 1 | Modem status register read strobe |
| xoff_det_i | input | 1 | Flow-stop character detected |
| spec_det_i | input | 1 | Special character detected |
| xon_rx_i | input | 1 | Flow-resume character received |
| cts_i | input | 1 | Clear-to-send input level |
| cts_auto_en_i | input | 1 | Automatic CTS flow control on |
| rts_i | input | 1 | Request-to-send output level |
| rts_auto_en_i | input | 1 | Automatic RTS flow control on |
| iir_rd_i | input | 1 | Identification register read strobe |
| irq_en_i | input | 7 | Per-source enables |
| pend_o | output | 7 | Raw pending latches |
| iir_o | output | 6 | Identification code |
| irq_o | output | 1 | Any enabled source pending |

## Verification
Two things can happen in the same cycle: a source's set event and its own clear event, and an identification read together with several pending sources. The bench provokes the first with a transmit write on the same edge as the empty rise, and with a special-character detect on the same edge as a receive push. It provokes the second by reading the identification register while several sources are pending. A behavioural reference model, compared on every clock, predicts the result. The set must win. The read must remove exactly the source it reported, and the next code must show the next source down.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int NSRC  = 7;
  localparam int IID_W = 6;

  typedef enum int {
    SRC_RXT = 0, SRC_TMO = 1, SRC_THRE = 2, SRC_MSR = 3,
    SRC_XOFF = 4, SRC_CTS = 5, SRC_RTS = 6
  } src_e;

  localparam logic [IID_W-1:0] ID_NONE = 6'h01;

  function automatic logic [IID_W-1:0] src_code(int idx);
    case (idx)
      SRC_RXT:  return 6'h04;
      SRC_TMO:  return 6'h0C;
      SRC_THRE: return 6'h02;
      SRC_MSR:  return 6'h00;
      SRC_XOFF: return 6'h10;
      default:  return 6'h20;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_latch.sv
`timescale 1ns/1ps
module uart_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_tmo.sv
`timescale 1ns/1ps
module uart_irq_tmo #(
  parameter int CNT_W     = 5,
  parameter int CHAR_BITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] level_i,
  input  logic             push_i,
  input  logic             rd_i,
  input  logic             tick_i,
  output logic             fire_o
);
  localparam int LIMIT = 4 * CHAR_BITS + 12;
  localparam int TW    = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LIM_V = TW'(LIMIT);

  logic [TW-1:0] cnt_q;
  logic          idle_restart;

  assign idle_restart = push_i | rd_i | (level_i == '0);
  assign fire_o = !idle_restart && tick_i && (cnt_q == LIM_V - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (idle_restart)             cnt_q <= '0;
    else if (tick_i && cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
module uart_irq_prio import uart_irq_pkg::*; (
  input  logic [NSRC-1:0]  act_i,
  output logic [NSRC-1:0]  sel_o,
  output logic [IID_W-1:0] id_o
);
  // lowest index wins: scan upward from the weakest
  always_comb begin
    sel_o = '0;
    id_o  = ID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        sel_o = '0;
        sel_o[i] = 1'b1;
        id_o  = src_code(i);
      end
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl import uart_irq_pkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int CHAR_BITS  = 10,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  rx_level_i,
  input  logic [CNT_W-1:0]  rx_trig_i,
  input  logic              rx_push_i,
  input  logic              rx_bit_tick_i,
  input  logic              rbr_rd_i,
  input  logic              thr_empty_i,
  input  logic              thr_wr_i,
  input  logic [3:0]        msr_delta_i,
  input  logic              msr_rd_i,
  input  logic              xoff_det_i,
  input  logic              spec_det_i,
  input  logic              xon_rx_i,
  input  logic              cts_i,
  input  logic              cts_auto_en_i,
  input  logic              rts_i,
  input  logic              rts_auto_en_i,
  input  logic              iir_rd_i,
  input  logic [NSRC-1:0]   irq_en_i,
  output logic [NSRC-1:0]   pend_o,
  output logic [IID_W-1:0]  iir_o,
  output logic              irq_o
);
  logic [NSRC-1:0] set_v, clr_v, sel, rd_clr;
  logic thr_q, cts_q, rts_q, spec_q, tmo_fire, at_trig;

  // edge history resets high so only a seen 0->1 counts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= 1'b1;
      cts_q  <= 1'b1;
      rts_q  <= 1'b1;
      spec_q <= 1'b0;
    end else begin
      thr_q <= thr_empty_i;
      cts_q <= cts_i;
      rts_q <= rts_i;
      if (set_v[SRC_XOFF]) spec_q <= spec_det_i;
    end
  end

  uart_irq_tmo #(.CNT_W(CNT_W), .CHAR_BITS(CHAR_BITS)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(rx_level_i),
    .push_i (rx_push_i),
    .rd_i   (rbr_rd_i),
    .tick_i (rx_bit_tick_i),
    .fire_o (tmo_fire)
  );

  uart_irq_prio u_prio (
    .act_i(pend_o & irq_en_i),
    .sel_o(sel),
    .id_o (iir_o)
  );

  assign rd_clr  = iir_rd_i ? sel : '0;
  assign at_trig = rx_level_i >= rx_trig_i;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[SRC_RXT]  = at_trig;
    clr_v[SRC_RXT]  = !at_trig;
    set_v[SRC_TMO]  = tmo_fire;
    clr_v[SRC_TMO]  = rbr_rd_i;
    set_v[SRC_THRE] = thr_empty_i & ~thr_q;
    clr_v[SRC_THRE] = thr_wr_i | rd_clr[SRC_THRE];
    set_v[SRC_MSR]  = |msr_delta_i;
    clr_v[SRC_MSR]  = msr_rd_i;
    set_v[SRC_XOFF] = xoff_det_i | spec_det_i;
    clr_v[SRC_XOFF] = xon_rx_i | rd_clr[SRC_XOFF] | (rx_push_i & spec_q);
    set_v[SRC_CTS]  = cts_auto_en_i & cts_i & ~cts_q;
    clr_v[SRC_CTS]  = msr_rd_i | rd_clr[SRC_CTS];
    set_v[SRC_RTS]  = rts_auto_en_i & rts_i & ~rts_q;
    clr_v[SRC_RTS]  = msr_rd_i | rd_clr[SRC_RTS];
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    uart_irq_latch u_lat (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[k]),
      .clr_i (clr_v[k]),
      .q_o   (pend_o[k])
    );
  end

  assign irq_o = |(pend_o & irq_en_i);
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
`timescale 1ns/1ps
module uart_irq_ctrl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] rx_level_i,
  input logic [CNT_W-1:0] rx_trig_i,
  input logic             rbr_rd_i,
  input logic             thr_empty_i,
  input logic             thr_wr_i,
  input logic [3:0]       msr_delta_i,
  input logic             msr_rd_i,
  input logic             xoff_det_i,
  input logic             spec_det_i,
  input logic             xon_rx_i,
  input logic             cts_i,
  input logic             rts_i,
  input logic [6:0]       pend_o,
  input logic [5:0]       iir_o,
  input logic             irq_o
);
  // R2
  rxt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pend_o[0] == ($past(rx_level_i) >= $past(rx_trig_i)));
  // R3
  tmo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbr_rd_i |=> !pend_o[1]);
  // R4
  thre_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i && !thr_empty_i |=> !pend_o[2]);
  // R5
  msr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[3] && !msr_rd_i |=> pend_o[3]);
  // R5
  msr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_delta_i != 4'h0) |=> pend_o[3]);
  // R6
  xoff_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xon_rx_i && !xoff_det_i && !spec_det_i |=> !pend_o[4]);
  // R7
  flow_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_rd_i && !cts_i && !rts_i |=> !pend_o[5] && !pend_o[6]);
  // R8
  none_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_o != 6'h01));
  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o != 7'h00);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_level_i (rx_level_i),
  .rx_trig_i  (rx_trig_i),
  .rbr_rd_i   (rbr_rd_i),
  .thr_empty_i(thr_empty_i),
  .thr_wr_i   (thr_wr_i),
  .msr_delta_i(msr_delta_i),
  .msr_rd_i   (msr_rd_i),
  .xoff_det_i (xoff_det_i),
  .spec_det_i (spec_det_i),
  .xon_rx_i   (xon_rx_i),
  .cts_i      (cts_i),
  .rts_i      (rts_i),
  .pend_o     (pend_o),
  .iir_o      (iir_o),
  .irq_o      (irq_o)
);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
  localparam int CW    = 5;
  localparam int LIMIT = 52;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [CW-1:0] rx_level_i = '0, rx_trig_i = 5'd4;
  logic rx_push_i = 0, rx_bit_tick_i = 0, rbr_rd_i = 0;
  logic thr_empty_i = 1, thr_wr_i = 0, msr_rd_i = 0;
  logic [3:0] msr_delta_i = '0;
  logic xoff_det_i = 0, spec_det_i = 0, xon_rx_i = 0;
  logic cts_i = 0, cts_auto_en_i = 0, rts_i = 0, rts_auto_en_i = 0;
  logic iir_rd_i = 0;
  logic [6:0] irq_en_i = 7'h7F;
  logic [6:0] pend_o;
  logic [5:0] iir_o;
  logic irq_o;

  always #5 clk_i = ~clk_i;

  uart_irq_ctrl u_dut (.*);

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string phase = "R1 reset";

  // reference model state
  bit [6:0] m_pend;
  int m_cnt;
  bit m_spec, m_thr, m_cts, m_rts;

  function automatic int top_src(bit [6:0] a);
    for (int i = 0; i < 7; i++) if (a[i]) return i;
    return -1;
  endfunction

  function automatic bit [5:0] code_of(int s);
    case (s)
      0: return 6'h04;  1: return 6'h0C;  2: return 6'h02;
      3: return 6'h00;  4: return 6'h10;  5, 6: return 6'h20;
      default: return 6'h01;
    endcase
  endfunction

  task automatic compare();
    bit [5:0] e_iir;
    e_iir = code_of(top_src(m_pend & irq_en_i));
    n_checks++;
    if (pend_o !== m_pend || iir_o !== e_iir || irq_o !== |(m_pend & irq_en_i)) begin
      n_fail++;
      $display("FAIL %s: pend=%h iir=%h irq=%b expected pend=%h iir=%h irq=%b",
               phase, pend_o, iir_o, irq_o, m_pend, e_iir, |(m_pend & irq_en_i));
    end
  endtask

  task automatic step();
    bit [6:0] n;
    int ts, nc;
    bit fire, xset;
    n  = m_pend;
    ts = top_src(m_pend & irq_en_i);
    n[0] = (rx_level_i >= rx_trig_i);
    nc = m_cnt; fire = 0;
    if (rx_push_i || rbr_rd_i || rx_level_i == 0) nc = 0;
    else if (rx_bit_tick_i && m_cnt < LIMIT) begin
      nc = m_cnt + 1;
      fire = (nc == LIMIT);
    end
    if (rbr_rd_i) n[1] = 0;
    if (fire) n[1] = 1;
    if (thr_wr_i || (iir_rd_i && ts == 2)) n[2] = 0;
    if (thr_empty_i && !m_thr) n[2] = 1;
    if (msr_rd_i) n[3] = 0;
    if (msr_delta_i != 0) n[3] = 1;
    if (xon_rx_i || (iir_rd_i && ts == 4) || (rx_push_i && m_spec)) n[4] = 0;
    xset = xoff_det_i || spec_det_i;
    if (xset) n[4] = 1;
    if (msr_rd_i || (iir_rd_i && ts == 5)) n[5] = 0;
    if (cts_auto_en_i && cts_i && !m_cts) n[5] = 1;
    if (msr_rd_i || (iir_rd_i && ts == 6)) n[6] = 0;
    if (rts_auto_en_i && rts_i && !m_rts) n[6] = 1;
    @(posedge clk_i);
    #1;
    m_pend = n; m_cnt = nc;
    if (xset) m_spec = spec_det_i;
    m_thr = thr_empty_i; m_cts = cts_i; m_rts = rts_i;
    rx_push_i = 0; rx_bit_tick_i = 0; rbr_rd_i = 0; thr_wr_i = 0;
    msr_rd_i = 0; msr_delta_i = 0; xoff_det_i = 0; spec_det_i = 0;
    xon_rx_i = 0; iir_rd_i = 0;
    compare();
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog in %s: actual hung expected finished", phase);
      finish_run();
    end
  end

  initial begin
    m_pend = 0; m_cnt = 0; m_spec = 0; m_thr = 1; m_cts = 1; m_rts = 1;
    #23;
    compare();                      // R1 during reset
    rst_ni = 1;
    #8;
    compare();                      // R1 after release
    idle(2);

    phase = "R2 trigger";
    for (int l = 0; l <= 6; l++) begin rx_level_i = CW'(l); rx_push_i = 1; step(); end
    iir_rd_i = 1; step(); msr_rd_i = 1; rbr_rd_i = 1; step();
    rx_level_i = 5'd3; rbr_rd_i = 1; step();
    rx_trig_i = 5'd2; step();
    rx_trig_i = 5'd8; step();
    rx_level_i = 5'd2; idle(2);

    phase = "R3 timeout";
    for (int i = 0; i < 30; i++) begin rx_bit_tick_i = 1; step(); end
    rx_push_i = 1; step();          // restart
    for (int i = 0; i < LIMIT - 1; i++) begin rx_bit_tick_i = 1; step(); end
    step();
    rx_bit_tick_i = 1; step();      // 52nd tick sets
    rx_bit_tick_i = 1; step(); idle(2);
    iir_rd_i = 1; step();           // R3 not cleared by id read
    rbr_rd_i = 1; step();
    rx_level_i = 0;
    for (int i = 0; i < 60; i++) begin rx_bit_tick_i = 1; step(); end

    phase = "R4 thre";
    thr_empty_i = 0; step(); thr_empty_i = 1; step(); idle(1);
    iir_rd_i = 1; step();
    thr_empty_i = 0; step(); thr_empty_i = 1; step();
    thr_wr_i = 1; thr_empty_i = 0; step();
    phase = "R11 set wins";
    thr_empty_i = 1; thr_wr_i = 1; step(); idle(1);
    spec_det_i = 1; rx_push_i = 1; step(); idle(1);
    phase = "R6 special";
    rx_push_i = 1; step();
    xoff_det_i = 1; step(); rx_push_i = 1; step(); idle(1);
    xon_rx_i = 1; step();
    spec_det_i = 1; step(); iir_rd_i = 1; step();   // thre outranks: xoff stays
    thr_wr_i = 1; thr_empty_i = 0; step();
    iir_rd_i = 1; step();

    phase = "R5 modem";
    msr_delta_i = 4'b0100; step();
    iir_rd_i = 1; step(); rbr_rd_i = 1; thr_wr_i = 1; step(); xon_rx_i = 1; step();
    msr_rd_i = 1; step();
    for (int b = 0; b < 4; b++) begin
      msr_delta_i = 4'(1 << b); step(); msr_rd_i = 1; step();
    end

    phase = "R7 flow";
    cts_i = 1; step(); cts_i = 0; step();
    cts_auto_en_i = 1; rts_auto_en_i = 1;
    cts_i = 1; step(); rts_i = 1; step(); idle(1);
    iir_rd_i = 1; step();
    iir_rd_i = 1; step();
    cts_i = 0; rts_i = 0; step();
    cts_i = 1; rts_i = 1; step();
    cts_i = 0; rts_i = 0; msr_rd_i = 1; step();

    phase = "R8 R10 priority";
    rx_level_i = 5'd1;
    thr_empty_i = 1; msr_delta_i = 4'h1; xoff_det_i = 1; cts_i = 1; rts_i = 1; step();
    for (int i = 0; i < 5; i++) begin iir_rd_i = 1; step(); end
    for (int i = 0; i < 40; i++) begin rx_bit_tick_i = 1; step(); end
    rx_level_i = 5'd9; step();
    rx_level_i = 5'd1; step();
    for (int i = 0; i < 20; i++) begin rx_bit_tick_i = 1; step(); end
    iir_rd_i = 1; step();
    msr_rd_i = 1; step(); rbr_rd_i = 1; step();

    phase = "R9 enables";
    xoff_det_i = 1; msr_delta_i = 4'h8; cts_i = 0; step();
    cts_i = 1; step();
    irq_en_i = 7'h00; idle(2);
    iir_rd_i = 1; step();           // none returned: nothing cleared
    irq_en_i = 7'b0110000; iir_rd_i = 1; step();
    irq_en_i = 7'b0100000; step();
    irq_en_i = 7'h7F; idle(1);
    msr_rd_i = 1; xon_rx_i = 1; step();
    rx_level_i = 0; idle(3);

    finish_run();
  end
endmodule